// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block collects event pulses from the channels of a multi-channel serial controller and turns them into interrupt state. Each channel keeps its own enable mask and status word. A command engine outside the block posts events into the status word, and software clears status bits by writing ones to them. Each channel owns one bit of a global summary word, and a single interrupt line is raised from that word.

Every channel also watches for the software acknowledge of a completed receive. If software clears a set receive-done bit while the command engine still reports a pending receive, the block emits a one-cycle re-arm strobe for that channel so the engine starts the next byte. On that same acknowledge the block evaluates the channel's interrupt state again.

All registers are reached through one write port and one combinational read port. The write port is addressed by channel and register select. Select encoding: 0 = enable, 1 = status, 2 = global summary (read only), 3 = unused, which reads 0 and ignores writes.

Top module: `chan_irq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, every enable word, every status word and the global summary read 0, `irq` is low and no re-arm strobe is active.
- R2: A write to select 0 keeps bits 14:0 of the written data as the channel's enable mask. Bit 15 is dropped and always reads 0.
- R3: A non-zero event pulse on a channel makes its status equal to (old status OR event) AND enable, visible one cycle later. The event uses the enable mask held before any enable write in the same cycle.
- R4: Posting an event discards every status bit that is not enabled, including bits latched earlier. If this leaves the status at zero, the global bit is not cleared.
- R5: When a posting leaves a channel's status non-zero, that channel's global bit is set in the same cycle that the status updates.
- R6: A write to select 1 clears every status bit whose written bit is 1, within bits 14:0. Bit 15 of status always reads 0.
- R7: A status write that leaves the channel's status at zero clears its global bit. A status write that leaves any bit set keeps the global bit.
- R8: `irq` is high exactly when at least one global bit is set, and it changes in the same cycle as the global word.
- R9: Writes to select 2 or 3 change no enable, status or global state.
- R10: A status write with bit 2 (receive done) set, while that channel's status bit 2 is set and its `rx_pending` is high, pulses that channel's `rx_rearm` for exactly one cycle, one cycle after the write. In every other case there is no pulse.
- R11: When a status write and an event reach the same channel in one cycle, the clear is applied first and the event is then posted under the mask.
- R12: A write or event addressed to one channel leaves every other channel's enable, status and global bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CHW | Channel addressed by the write |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | DATA_W | Write data |
| rd_ch | input | CHW | Channel addressed by the read |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | DATA_W | Combinational read data |
| evt_pulse | input | NCH*SW | Per-channel event bits, channel c at [c*SW +: SW] |
| rx_pending | input | NCH | Receive command still pending, per channel |
| rx_rearm | output | NCH | One-cycle request to start the next receive |
| gstat | output | NCH | Global summary, one bit per channel |
| irq | output | 1 | Shared interrupt line |

## Verification
Every register update lands on the clock edge that samples the write or event. Status, enable, global bits and `irq` are therefore due one edge after the stimulus, and `rx_rearm` is due on that same edge and drops on the next. The bench applies inputs just after a falling edge. It samples outputs and the read port at the following falling edge, half a period after the due edge, and then checks a second time one cycle later to confirm the re-arm strobe has ended. Expected values come from a per-channel arithmetic model that the bench updates in step with each cycle it applies.

// File: rtl/chan_irq_pkg.sv
// Package: shared register-select encoding and status bit positions for
// the interrupt aggregator. Assumes select values are decoded as 2 bits.
package chan_irq_pkg;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_GLOBAL = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Status bit that marks a finished receive; its acknowledge re-arms RX.
    localparam int RXDONE_BIT = 2;

endpackage

// File: rtl/chan_irq_channel.sv
// Module: per-channel enable mask and status word.
// Posts masked events, applies write-one-to-clear, produces set/clear
// requests for the channel's global bit and the RX re-arm strobe.
// Assumes the write strobes are already decoded for this channel.
module chan_irq_channel #(
    parameter int SW     = 15,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              st_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SW-1:0]     evt,
    input  logic              rx_pending,
    output logic [DATA_W-1:0] en_q,
    output logic [DATA_W-1:0] st_q,
    output logic              g_set,
    output logic              g_clr,
    output logic              rx_rearm
);
    import chan_irq_pkg::*;

    localparam logic [DATA_W-1:0] KEEP = DATA_W'((64'd1 << SW) - 64'd1);

    logic [DATA_W-1:0] clr_bits;
    logic [DATA_W-1:0] evt_ext;
    logic [DATA_W-1:0] st_next;
    logic              rearm_now;
    logic              evaluate;

    // Decode the clear mask, re-arm condition and next status value.
    always_comb begin
        clr_bits  = st_wr ? (wr_data & KEEP) : '0;
        evt_ext   = DATA_W'(evt);
        rearm_now = st_wr && wr_data[RXDONE_BIT] && st_q[RXDONE_BIT] && rx_pending;
        evaluate  = (|evt) || rearm_now;
        if (evaluate) begin
            st_next = ((st_q & ~clr_bits) | evt_ext) & en_q;
        end else begin
            st_next = st_q & ~clr_bits;
        end
        g_set = evaluate && (st_next != '0);
        g_clr = !g_set && st_wr && (st_next == '0);
    end

    // Hold the enable mask; upper bits are forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= wr_data & KEEP;
        end
    end

    // Hold the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_next;
        end
    end

    // Register the one-cycle receive re-arm strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_rearm <= 1'b0;
        end else begin
            rx_rearm <= rearm_now;
        end
    end

endmodule

// File: rtl/chan_irq_rollup.sv
// Module: global per-channel summary word and shared interrupt line.
// Assumes set and clear requests for one channel never arrive together.
module chan_irq_rollup #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] g_set,
    input  logic [NCH-1:0] g_clr,
    output logic [NCH-1:0] gstat,
    output logic           irq
);

    // Update each channel's summary bit from its set/clear requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gstat <= '0;
        end else begin
            gstat <= (gstat | g_set) & ~g_clr;
        end
    end

    // Drive the shared line from the summary word.
    always_comb begin
        irq = |gstat;
    end

endmodule

// File: rtl/chan_irq_aggregator.sv
// Module: top of the interrupt aggregator. Decodes the register port,
// instantiates one channel slice per channel and the global roll-up.
// Assumes NCH < DATA_W and SW < DATA_W so the summary fits one read word.
module chan_irq_aggregator #(
    parameter int NCH    = 4,
    parameter int SW     = 15,
    parameter int DATA_W = 16,
    parameter int CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHW-1:0]    wr_ch,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [CHW-1:0]    rd_ch,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NCH*SW-1:0] evt_pulse,
    input  logic [NCH-1:0]    rx_pending,
    output logic [NCH-1:0]    rx_rearm,
    output logic [NCH-1:0]    gstat,
    output logic              irq
);
    import chan_irq_pkg::*;

    logic [NCH-1:0]             en_wr;
    logic [NCH-1:0]             st_wr;
    logic [NCH-1:0]             g_set;
    logic [NCH-1:0]             g_clr;
    logic [NCH-1:0][DATA_W-1:0] en_all;
    logic [NCH-1:0][DATA_W-1:0] stat_all;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        // Decode write strobes for this channel.
        always_comb begin
            en_wr[c] = wr_en && (wr_ch == CHW'(c)) && (wr_sel == SEL_ENABLE);
            st_wr[c] = wr_en && (wr_ch == CHW'(c)) && (wr_sel == SEL_STATUS);
        end

        chan_irq_channel #(
            .SW    (SW),
            .DATA_W(DATA_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_wr     (en_wr[c]),
            .st_wr     (st_wr[c]),
            .wr_data   (wr_data),
            .evt       (evt_pulse[c*SW +: SW]),
            .rx_pending(rx_pending[c]),
            .en_q      (en_all[c]),
            .st_q      (stat_all[c]),
            .g_set     (g_set[c]),
            .g_clr     (g_clr[c]),
            .rx_rearm  (rx_rearm[c])
        );
    end

    chan_irq_rollup #(
        .NCH(NCH)
    ) u_rollup (
        .clk  (clk),
        .rst_n(rst_n),
        .g_set(g_set),
        .g_clr(g_clr),
        .gstat(gstat),
        .irq  (irq)
    );

    // Combinational read mux over channel registers and the summary word.
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_ENABLE: begin
                for (int c = 0; c < NCH; c++) begin
                    if (rd_ch == CHW'(c)) rd_data = en_all[c];
                end
            end
            SEL_STATUS: begin
                for (int c = 0; c < NCH; c++) begin
                    if (rd_ch == CHW'(c)) rd_data = stat_all[c];
                end
            end
            SEL_GLOBAL: rd_data = DATA_W'(gstat);
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/chan_irq_aggregator_chk.sv
// Checker: temporal properties of the aggregator, bound to the top module.
module chan_irq_aggregator_chk #(
    parameter int NCH    = 4,
    parameter int SW     = 15,
    parameter int DATA_W = 16,
    parameter int CHW    = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [CHW-1:0]               wr_ch,
    input logic [1:0]                   wr_sel,
    input logic [DATA_W-1:0]            wr_data,
    input logic [NCH*SW-1:0]            evt_pulse,
    input logic [NCH-1:0]               rx_pending,
    input logic [NCH-1:0]               rx_rearm,
    input logic [NCH-1:0]               gstat,
    input logic                         irq,
    input logic [NCH-1:0][DATA_W-1:0]   stat_all
);

    // R1: a reset cycle leaves the summary and the line low.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (gstat == '0 && !irq && rx_rearm == '0));

    // R5: the line can only rise after an event or a register write.
    p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|evt_pulse) || $past(wr_en)));

    // R7: the line only falls after a status write.
    p_irq_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en && wr_sel == 2'd1));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R5: a channel with a clear summary bit holds no status.
        p_gbit_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !gstat[c] |-> (stat_all[c] == '0));

        // R10: a re-arm pulse follows an acknowledge of a set RX_DONE with RX pending.
        p_rearm_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
            rx_rearm[c] |-> $past(wr_en && wr_sel == 2'd1 && wr_ch == CHW'(c)
                                  && wr_data[2] && stat_all[c][2] && rx_pending[c]));

        // R6: bit 15 of a status word never sets.
        p_no_top_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
            stat_all[c][DATA_W-1] == 1'b0);
    end

endmodule

bind chan_irq_aggregator chan_irq_aggregator_chk #(
    .NCH   (NCH),
    .SW    (SW),
    .DATA_W(DATA_W),
    .CHW   (CHW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_ch     (wr_ch),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .evt_pulse (evt_pulse),
    .rx_pending(rx_pending),
    .rx_rearm  (rx_rearm),
    .gstat     (gstat),
    .irq       (irq),
    .stat_all  (stat_all)
);

// File: tb/chan_irq_aggregator_bench.sv
// Bench: sweeps every status bit on every channel plus the masking,
// clear, re-arm and collision corners against an arithmetic model.
module chan_irq_aggregator_bench;
    localparam int NCH    = 4;
    localparam int SW     = 15;
    localparam int DATA_W = 16;
    localparam int CHW    = 2;
    localparam logic [15:0] KEEP = 16'h7FFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [CHW-1:0]    wr_ch = '0;
    logic [1:0]        wr_sel = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [CHW-1:0]    rd_ch = '0;
    logic [1:0]        rd_sel = '0;
    logic [DATA_W-1:0] rd_data;
    logic [NCH*SW-1:0] evt_pulse = '0;
    logic [NCH-1:0]    rx_pending = '0;
    logic [NCH-1:0]    rx_rearm;
    logic [NCH-1:0]    gstat;
    logic              irq;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0]    m_en [NCH];
    logic [15:0]    m_st [NCH];
    logic [NCH-1:0] m_g;
    logic [NCH-1:0] m_rearm;

    always #4 clk = ~clk;

    chan_irq_aggregator #(
        .NCH(NCH), .SW(SW), .DATA_W(DATA_W), .CHW(CHW)
    ) u_chan_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_ch(rd_ch), .rd_sel(rd_sel),
        .rd_data(rd_data), .evt_pulse(evt_pulse), .rx_pending(rx_pending),
        .rx_rearm(rx_rearm), .gstat(gstat), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input int ch, input logic [1:0] sel, output logic [15:0] v);
        rd_ch  = CHW'(ch);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    // Compare every output and every readable register with the model.
    task automatic check_all(input string tag);
        logic [15:0] v;
        chk({tag, " gstat"}, 32'(gstat), 32'(m_g));
        chk({tag, " irq"}, 32'(irq), 32'(|m_g));
        chk({tag, " rearm"}, 32'(rx_rearm), 32'(m_rearm));
        for (int c = 0; c < NCH; c++) begin
            read_reg(c, 2'd0, v);
            chk({tag, " enable"}, 32'(v), 32'(m_en[c]));
            read_reg(c, 2'd1, v);
            chk({tag, " status"}, 32'(v), 32'(m_st[c]));
        end
        read_reg(0, 2'd2, v);
        chk({tag, " global"}, 32'(v), 32'(m_g));
        read_reg(0, 2'd3, v);
        chk({tag, " unused"}, 32'(v), 32'h0);
    endtask

    // Apply one cycle of stimulus and advance the model to match.
    task automatic cycle(input logic we, input int ch, input logic [1:0] sel,
                         input logic [15:0] data, input logic [NCH*SW-1:0] ev);
        logic [15:0] clr, e, nx;
        logic hit, rearm, eval_now;
        wr_en = we; wr_ch = CHW'(ch); wr_sel = sel; wr_data = data; evt_pulse = ev;
        for (int c = 0; c < NCH; c++) begin
            hit      = we && (ch == c) && (sel == 2'd1);
            clr      = hit ? (data & KEEP) : 16'h0;
            e        = 16'(ev[c*SW +: SW]);
            rearm    = hit && data[2] && m_st[c][2] && rx_pending[c];
            eval_now = (e != 0) || rearm;
            nx       = eval_now ? (((m_st[c] & ~clr) | e) & m_en[c]) : (m_st[c] & ~clr);
            if (eval_now && nx != 0) m_g[c] = 1'b1;
            else if (hit && nx == 0) m_g[c] = 1'b0;
            m_st[c]    = nx;
            m_rearm[c] = rearm;
            if (we && (ch == c) && (sel == 2'd0)) m_en[c] = data & KEEP;
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; evt_pulse = '0;
    endtask

    task automatic idle();
        cycle(1'b0, 0, 2'd0, 16'h0, '0);
    endtask

    function automatic logic [NCH*SW-1:0] ev_on(input int ch, input logic [14:0] bits);
        logic [NCH*SW-1:0] v = '0;
        v[ch*SW +: SW] = bits;
        return v;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        for (int c = 0; c < NCH; c++) begin m_en[c] = 0; m_st[c] = 0; end
        m_g = '0; m_rearm = '0;
        // Put ones on the bus during reset so R1 is a real test.
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'hFFFF;
        repeat (3) @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b1;
        check_all("R1 reset");

        // R2: enable keeps bits 14:0 only, per channel (also R12 isolation).
        for (int c = 0; c < NCH; c++) begin
            cycle(1'b1, c, 2'd0, 16'hFFFF ^ 16'(c << 4), '0);
            check_all("R2 enable mask");
        end
        for (int c = 0; c < NCH; c++) cycle(1'b1, c, 2'd0, 16'h7FFF, '0);
        check_all("R2 enable all");

        // R3/R5/R8/R6/R7/R12: sweep every status bit on every channel.
        for (int c = 0; c < NCH; c++) begin
            for (int b = 0; b < SW; b++) begin
                cycle(1'b0, 0, 2'd0, 16'h0, ev_on(c, 15'(1 << b)));
                check_all("R3 R5 R8 R12 post");
                cycle(1'b1, c, 2'd1, 16'(1 << b) | 16'h8000, '0);
                check_all("R6 R7 clear");
            end
        end

        // R7: partial clear keeps the global bit.
        cycle(1'b0, 0, 2'd0, 16'h0, ev_on(1, 15'h0003));
        cycle(1'b1, 1, 2'd1, 16'h0001, '0);
        check_all("R7 partial clear");
        cycle(1'b1, 1, 2'd1, 16'h0002, '0);
        check_all("R7 final clear");

        // R4: disabled bits are discarded, including earlier latched bits.
        cycle(1'b1, 2, 2'd0, 16'h00F0, '0);
        cycle(1'b0, 0, 2'd0, 16'h0, ev_on(2, 15'h7FFF));
        check_all("R4 masked post");
        cycle(1'b1, 2, 2'd0, 16'h0000, '0);
        cycle(1'b0, 0, 2'd0, 16'h0, ev_on(2, 15'h0001));
        check_all("R4 status zero global kept");
        cycle(1'b1, 2, 2'd1, 16'h0000, '0);
        check_all("R7 empty write clears global");
        cycle(1'b1, 2, 2'd0, 16'h7FFF, '0);

        // R9: writes to the global and unused selects have no effect.
        cycle(1'b0, 0, 2'd0, 16'h0, ev_on(3, 15'h0010));
        cycle(1'b1, 3, 2'd2, 16'h0000, '0);
        check_all("R9 global write");
        cycle(1'b1, 3, 2'd3, 16'hFFFF, '0);
        check_all("R9 unused write");
        cycle(1'b1, 3, 2'd1, 16'hFFFF, '0);

        // R11: clear then post in the same cycle.
        cycle(1'b0, 0, 2'd0, 16'h0, ev_on(0, 15'h0003));
        cycle(1'b1, 0, 2'd1, 16'h0001, ev_on(0, 15'h0004));
        check_all("R11 collision");
        cycle(1'b1, 0, 2'd1, 16'hFFFF, ev_on(0, 15'h0001));
        check_all("R11 clear all then post");
        cycle(1'b1, 0, 2'd1, 16'hFFFF, '0);

        // R10: re-arm with pending, without pending, and with bit 2 clear.
        rx_pending = 4'b0100;
        cycle(1'b0, 0, 2'd0, 16'h0, ev_on(2, 15'h0005));
        cycle(1'b1, 2, 2'd1, 16'h0004, '0);
        check_all("R10 rearm pulse");
        idle();
        check_all("R10 rearm one cycle");
        cycle(1'b1, 2, 2'd1, 16'h0004, '0);
        check_all("R10 no rearm bit clear");
        cycle(1'b0, 0, 2'd0, 16'h0, ev_on(1, 15'h0004));
        cycle(1'b1, 1, 2'd1, 16'h0004, '0);
        check_all("R10 no rearm not pending");
        rx_pending = '0;
        cycle(1'b1, 2, 2'd1, 16'hFFFF, '0);
        check_all("R7 all clear");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule